// File: doc/BRIEF.md
# Prerouted Mesh Crossing Switch

This block is the switch at a four-way crossing in a mesh of lanes. It has four lane ports, one per compass side, and a fifth local port through which the attached processing element injects and ejects flits. Each incoming port has a single-entry slot that holds one flit. A flit moves only into an empty place, so gaps ("bubbles") open behind moving flits and close up when traffic stalls.

The source computes the route before the flit leaves. The route is a word with two set marker bits. No switch compares coordinates. Each switch looks at the lowest route bit of a flit that arrives on a lane:
- If the bit is clear, the flit goes straight on.
- If the bit is set and another marker is still present, the flit turns left or right, as a one-bit flag in the flit selects.
- If the bit is set and it is the last marker, the flit leaves at the local port.

On every lane-to-lane or lane-to-local hop the route word goes out shifted right by one place, so a used marker drops off. A locally injected flit goes out unshifted on the lane that its side-band direction selects.

Each output accepts one flit per cycle. A fixed priority picks the winner, and a flit that loses stays in its slot. An output offers a flit only while the slot beyond it is reported empty.

Top module: `mesh_xing_switch`

## Requirements
- R1: During reset every output valid is low and every input slot reports empty (in_empty all ones).
- R2: A flit offered to an empty slot is captured at the clock edge, and the slot then reports not empty. A flit offered to an occupied slot is dropped, and the held flit is unchanged.
- R3: A lane flit whose route bit 0 is clear leaves on the opposite lane in the cycle after capture. Its route field is shifted right by one, and its turn flag and data are unchanged. Port indices are N=0, E=1, S=2, W=3, local=4.
- R4: A lane flit whose route bit 0 is set, and which has another route bit set, turns. With flag=1 (left) it leaves on port (i+1) mod 4. With flag=0 (right) it leaves on port (i+3) mod 4. Its route is shifted right by one.
- R5: A lane flit whose route bit 0 is the only set route bit leaves at the local output with an all-zero route field.
- R6: A local flit leaves on the lane chosen by the 2-bit loc_dir that was sampled with it, with its route field unshifted.
- R7: An output is valid only while its dn_empty is high. While an output is blocked, its flit stays in the slot unchanged.
- R8: When several flits want the same lane output, the straight flit wins first, then the left-turning flit, then the right-turning flit, then the local flit. Each loser goes out in a later cycle in that order.
- R9: When several lane flits want the local output, port N wins over E, E over S, and S over W.
- R10: A slot that sends its flit at a clock edge cannot capture at that same edge. It reports empty in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 5 | Flit offered on each input port |
| in_flit | input | 5 x (RW+1+DW) | Input flits: route [top RW bits], turn flag, data [DW bits] |
| loc_dir | input | 2 | First lane for a locally injected flit |
| in_empty | output | 5 | Input slot empty, seen by the upstream sender |
| out_valid | output | 5 | Flit presented on each output port |
| out_flit | output | 5 x (RW+1+DW) | Output flits |
| dn_empty | input | 5 | Downstream slot beyond each output is empty |

## Verification
The bench builds the switch with an 8-bit route field and 8-bit data. In these narrow words, the route after the shift, the flag and the data can each be read as a short hex value. A route whose only marker sits at bit 0 is also easy to write. Blocking single outputs with dn_empty queues up to four contenders, and the bench then watches them leave one per cycle in priority order. The same setup covers dropped offers to full slots.

// File: rtl/mesh_xing_switch.sv
module mesh_xing_switch #(
  parameter int RW = 32,
  parameter int DW = 32,
  localparam int FW = RW + 1 + DW,
  localparam int NP = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          in_valid,
  input  logic [NP-1:0][FW-1:0]  in_flit,
  input  logic [1:0]             loc_dir,
  output logic [NP-1:0]          in_empty,
  output logic [NP-1:0]          out_valid,
  output logic [NP-1:0][FW-1:0]  out_flit,
  input  logic [NP-1:0]          dn_empty
);
  localparam logic [2:0] LOC = 3'd4;

  logic [NP-1:0]         occ, fire;
  logic [NP-1:0][FW-1:0] slot, fwd;
  logic [NP-1:0][2:0]    dst;
  logic [1:0]            ldir;

  assign in_empty = ~occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ  <= '0;
      slot <= '0;
      ldir <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (occ[i]) begin
          if (fire[i]) occ[i] <= 1'b0;
        end else if (in_valid[i]) begin
          occ[i]  <= 1'b1;
          slot[i] <= in_flit[i];
          if (i == NP - 1) ldir <= loc_dir;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      fwd[i] = {1'b0, slot[i][FW-1:DW+2], slot[i][DW:0]};
      if (!slot[i][DW+1])
        dst[i] = 3'((i + 2) % 4);
      else if (|slot[i][FW-1:DW+2])
        dst[i] = slot[i][DW] ? 3'((i + 1) % 4) : 3'((i + 3) % 4);
      else
        dst[i] = LOC;
    end
    fwd[NP-1] = slot[NP-1];
    dst[NP-1] = {1'b0, ldir};
  end

  function automatic logic [2:0] cand(int o, int k);
    if (o == NP - 1) return 3'(k);
    case (k)
      0:       return 3'((o + 2) % 4);
      1:       return 3'((o + 3) % 4);
      2:       return 3'((o + 1) % 4);
      default: return LOC;
    endcase
  endfunction

  always_comb begin : arb
    logic       hit;
    logic [2:0] w, c;
    out_valid = '0;
    out_flit  = '0;
    fire      = '0;
    for (int o = 0; o < NP; o++) begin
      hit = 1'b0;
      w   = '0;
      for (int k = 3; k >= 0; k--) begin
        c = cand(o, k);
        if (occ[c] && dst[c] == 3'(o)) begin
          hit = 1'b1;
          w   = c;
        end
      end
      if (hit && dn_empty[o]) begin
        out_valid[o] = 1'b1;
        out_flit[o]  = fwd[w];
        fire[w]      = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_chk
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && !occ[i]) |=> (occ[i] && slot[i] == $past(in_flit[i])));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[i] && !fire[i]) |=> (occ[i] && $stable(slot[i])));
    // R10
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |=> in_empty[i]);
    // R7
    flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[i] |-> dn_empty[i]);
  end

  // R5
  eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[NP-1] |-> (out_flit[NP-1][FW-1:DW+1] == '0));

  // R8
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) <= $countones(occ));
endmodule

// File: tb/tb_mesh_xing_switch.sv
module tb_mesh_xing_switch;
  localparam int RW = 8;
  localparam int DW = 8;
  localparam int FW = RW + 1 + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] in_valid = '0;
  logic [4:0][FW-1:0] in_flit = '0;
  logic [1:0] loc_dir = '0;
  logic [4:0] in_empty, out_valid;
  logic [4:0][FW-1:0] out_flit;
  logic [4:0] dn_empty = 5'h1f;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mesh_xing_switch #(.RW(RW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .loc_dir(loc_dir), .in_empty(in_empty), .out_valid(out_valid),
    .out_flit(out_flit), .dn_empty(dn_empty)
  );

  always #10 clk = ~clk;

  function automatic logic [FW-1:0] mk(logic [7:0] r, logic l, logic [7:0] d);
    return {r, l, d};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic offer(int p, logic [FW-1:0] f);
    in_valid[p] = 1'b1;
    in_flit[p]  = f;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid in reset", 32'(out_valid), 32'h0);
    chk("R1 in_empty in reset", 32'(in_empty), 32'h1f);
  endtask

  task automatic t_straight();
    offer(0, mk(8'b0000_0110, 1'b0, 8'hA5));
    offer(1, mk(8'b0000_1000, 1'b1, 8'h3C));
    step();
    chk("R3 straight valid", 32'(out_valid), 32'b01100);
    chk("R3 N to S flit", 32'(out_flit[2]), 32'(mk(8'b0000_0011, 1'b0, 8'hA5)));
    chk("R3 E to W flit", 32'(out_flit[3]), 32'(mk(8'b0000_0100, 1'b1, 8'h3C)));
    chk("R2 slots held", 32'(in_empty), 32'b11100);
    step();
    chk("R10 slots empty after send", 32'(in_empty), 32'h1f);
    chk("R10 no output after send", 32'(out_valid), 32'h0);
  endtask

  task automatic t_turn();
    offer(3, mk(8'b0100_0001, 1'b1, 8'h11));
    offer(1, mk(8'b1000_0001, 1'b1, 8'h22));
    offer(2, mk(8'b0000_0011, 1'b0, 8'h33));
    step();
    chk("R4 turn valid", 32'(out_valid), 32'b00111);
    chk("R4 W left to N", 32'(out_flit[0]), 32'(mk(8'b0010_0000, 1'b1, 8'h11)));
    chk("R4 E left to S", 32'(out_flit[2]), 32'(mk(8'b0100_0000, 1'b1, 8'h22)));
    chk("R4 S right to E", 32'(out_flit[1]), 32'(mk(8'b0000_0001, 1'b0, 8'h33)));
    step();
    chk("R4 drained", 32'(out_valid), 32'h0);
  endtask

  task automatic t_exit();
    offer(2, mk(8'b0000_0001, 1'b1, 8'h44));
    step();
    chk("R5 exit valid", 32'(out_valid), 32'b10000);
    chk("R5 exit flit", 32'(out_flit[4]), 32'(mk(8'h00, 1'b1, 8'h44)));
    step();
  endtask

  task automatic t_inject();
    loc_dir = 2'd3;
    offer(4, mk(8'b0001_0100, 1'b1, 8'h66));
    step();
    loc_dir = 2'd0;
    chk("R6 inject valid", 32'(out_valid), 32'b01000);
    chk("R6 inject flit", 32'(out_flit[3]), 32'(mk(8'b0001_0100, 1'b1, 8'h66)));
    step();
  endtask

  task automatic t_block();
    dn_empty[2] = 1'b0;
    offer(0, mk(8'b0000_0010, 1'b0, 8'h77));
    step();
    chk("R7 blocked output", 32'(out_valid), 32'h0);
    chk("R7 slot held", 32'(in_empty[0]), 32'h0);
    offer(0, mk(8'b0000_0010, 1'b0, 8'h88));
    step();
    chk("R7 still blocked", 32'(out_valid), 32'h0);
    dn_empty[2] = 1'b1;
    offer(0, mk(8'b0000_0010, 1'b0, 8'h99));
    #1;
    chk("R7 released valid", 32'(out_valid), 32'b00100);
    chk("R2 full-slot offer dropped", 32'(out_flit[2]), 32'(mk(8'b0000_0001, 1'b0, 8'h77)));
    step();
    chk("R10 no capture at send edge", 32'(in_empty), 32'h1f);
    chk("R10 nothing left", 32'(out_valid), 32'h0);
  endtask

  task automatic t_lane_prio();
    dn_empty = 5'b11110;
    offer(2, mk(8'b0000_0010, 1'b0, 8'hA1));
    offer(3, mk(8'b0000_0011, 1'b1, 8'hA2));
    offer(1, mk(8'b0000_0011, 1'b0, 8'hA3));
    offer(4, mk(8'b0000_0000, 1'b0, 8'hA4));
    step();
    chk("R2 four slots held", 32'(in_empty), 32'b00001);
    dn_empty = 5'h1f;
    #1;
    chk("R8 one winner", 32'(out_valid), 32'b00001);
    chk("R8 straight first", 32'(out_flit[0][7:0]), 32'hA1);
    step();
    chk("R8 left turn second", 32'(out_flit[0][7:0]), 32'hA2);
    step();
    chk("R8 right turn third", 32'(out_flit[0][7:0]), 32'hA3);
    step();
    chk("R8 local last", 32'(out_flit[0][7:0]), 32'hA4);
    step();
    chk("R8 drained", 32'(out_valid), 32'h0);
  endtask

  task automatic t_local_prio();
    dn_empty = 5'b01111;
    offer(3, mk(8'b0000_0001, 1'b0, 8'hB3));
    offer(2, mk(8'b0000_0001, 1'b0, 8'hB2));
    offer(0, mk(8'b0000_0001, 1'b0, 8'hB0));
    step();
    dn_empty = 5'h1f;
    #1;
    chk("R9 N first", 32'(out_flit[4][7:0]), 32'hB0);
    step();
    chk("R9 S second", 32'(out_flit[4][7:0]), 32'hB2);
    step();
    chk("R9 W third", 32'(out_flit[4][7:0]), 32'hB3);
    step();
    chk("R9 drained", 32'(out_valid), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_straight();
    t_turn();
    t_exit();
    t_inject();
    t_block();
    t_lane_prio();
    t_local_prio();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule